// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Unit

This unit holds the event flags of an I2C master controller and turns them into one interrupt request. The bus engine reports each event (address phase finished, a byte received, a byte sent, the transmit holding register emptied, a stop condition issued, arbitration lost, a NACK seen) as a one-cycle pulse. The unit keeps each pulse as a sticky flag until software clears it.

Software reaches two words through a word-wide register port. The status word is cleared selectively. A 0 in the written data clears that flag and a 1 leaves it alone, so software can acknowledge a subset of events (for example address-done together with data-empty) and let the engine move on to the next byte. The enable word masks the flags, and the interrupt line is high while any enabled flag is set. Reads of any other offset return zero, and writes to any other offset change nothing.

Top module: `i2cm_stat_irq`

## Requirements
- R1: After reset the status word and the enable word read as zero and the interrupt output is low.
- R2: A one-cycle pulse on event input bit i sets status bit i, and the bit stays set after the pulse ends. Bit positions: 0 address phase done, 1 byte received, 2 byte transmitted, 3 transmit register empty, 4 stop issued, 5 arbitration lost, 6 NACK received.
- R3: A write to the status word at offset 0x0C clears each status bit whose written data bit is 0 and leaves unchanged each status bit whose written data bit is 1. Writing all zeros clears every bit.
- R4: When an event pulse and a status write that would clear the same bit happen in the same cycle, the bit ends up set.
- R5: A write to offset 0x14 loads the enable word, one enable per event at the same bit positions as the status word, and a read of 0x14 returns it.
- R6: The interrupt output is high exactly while at least one status bit and its enable bit are both set. It stays high until every such bit is cleared or disabled.
- R7: Bits 31 down to 7 of both words read as zero, and writing ones to them has no effect.
- R8: Reads of any offset other than 0x0C and 0x14 return zero, and writes to such offsets leave both words unchanged.
- R9: Writing a pattern that clears only address-done and transmit-empty (or only address-done and byte-received) leaves every other pending status bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_pulse | input | 7 | One-cycle event pulses from the bus engine |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to produce is the collision: a status write that clears a bit and an event pulse that sets the same bit, both in one clock cycle. The bench drives the write strobe and the pulse on the same falling edge, so both are present at the same rising edge. It then reads the status word back. The interrupt logic is swept over every enable value against several status patterns, and the write-zero-to-clear rule is swept over all 128 data patterns, each time starting from a full status word.

// File: rtl/i2cm_evt_pkg.sv
package i2cm_evt_pkg;
   localparam int unsigned EVT_COUNT = 7;

   typedef enum logic [2:0] {
      EVT_ADDR_DONE  = 3'd0,
      EVT_RX_READY   = 3'd1,
      EVT_TX_DONE    = 3'd2,
      EVT_TX_EMPTY   = 3'd3,
      EVT_STOP_DONE  = 3'd4,
      EVT_ARB_LOST   = 3'd5,
      EVT_NACK       = 3'd6
   } evt_idx_e;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_ENA  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/i2cm_sticky_bit.sv
module i2cm_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic keep_i,
   output logic q_o
);
   logic q_q;

   // Set has priority over a clearing write in the same cycle.
   always_ff @(posedge clk) begin
      if (!rst_n)
         q_q <= 1'b0;
      else if (set_i)
         q_q <= 1'b1;
      else if (wr_i && !keep_i)
         q_q <= 1'b0;
   end

   assign q_o = q_q;
endmodule

// File: rtl/i2cm_regport.sv
module i2cm_regport
   import i2cm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_EV   = 7,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C,
   parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h14
) (
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [NUM_EV-1:0] stat_i,
   input  logic [NUM_EV-1:0] ena_i,
   output logic              stat_wr_o,
   output logic              ena_wr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_EV;

   reg_sel_e sel;

   always_comb begin
      if (addr_i == STAT_OFS)
         sel = SEL_STAT;
      else if (addr_i == ENA_OFS)
         sel = SEL_ENA;
      else
         sel = SEL_NONE;
   end

   assign stat_wr_o = wr_i && (sel == SEL_STAT);
   assign ena_wr_o  = wr_i && (sel == SEL_ENA);

   always_comb begin
      case (sel)
         SEL_STAT: rdata_o = {{PAD_W{1'b0}}, stat_i};
         SEL_ENA:  rdata_o = {{PAD_W{1'b0}}, ena_i};
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/i2cm_irq_merge.sv
module i2cm_irq_merge #(
   parameter int unsigned NUM_EV  = 7,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EV-1:0] stat_i,
   input  logic [NUM_EV-1:0] ena_i,
   output logic              irq_o
);
   logic any_hit;

   assign any_hit = |(stat_i & ena_i);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= any_hit;
         end
         assign irq_o = irq_q;
      end else begin : g_comb
         assign irq_o = any_hit;
      end
   endgenerate
endmodule

// File: rtl/i2cm_stat_irq.sv
module i2cm_stat_irq
   import i2cm_evt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_EV   = EVT_COUNT,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C,
   parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h14,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_EV-1:0] evt_pulse,
   output logic              irq
);
   if (NUM_EV == 0 || NUM_EV > DATA_W) begin : g_bad_width
      $error("NUM_EV must be between 1 and DATA_W");
   end
   if (STAT_OFS == ENA_OFS) begin : g_bad_ofs
      $error("status and enable offsets must differ");
   end

   logic [NUM_EV-1:0] stat_q;
   logic [NUM_EV-1:0] ena_q;
   logic              stat_wr;
   logic              ena_wr;

   i2cm_regport #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NUM_EV  (NUM_EV),
      .STAT_OFS(STAT_OFS),
      .ENA_OFS (ENA_OFS)
   ) u_port (
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .stat_i   (stat_q),
      .ena_i    (ena_q),
      .stat_wr_o(stat_wr),
      .ena_wr_o (ena_wr),
      .rdata_o  (reg_rdata)
   );

   for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
      i2cm_sticky_bit u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (evt_pulse[i]),
         .wr_i  (stat_wr),
         .keep_i(reg_wdata[i]),
         .q_o   (stat_q[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ena_q <= '0;
      else if (ena_wr)
         ena_q <= reg_wdata[NUM_EV-1:0];
   end

   i2cm_irq_merge #(
      .NUM_EV (NUM_EV),
      .REG_OUT(IRQ_REG)
   ) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .stat_i(stat_q),
      .ena_i (ena_q),
      .irq_o (irq)
   );
endmodule

// File: rtl/i2cm_stat_irq_chk.sv
module i2cm_stat_irq_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_EV   = 7,
   parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C,
   parameter logic [ADDR_W-1:0] ENA_OFS  = 8'h14,
   parameter bit          IRQ_REG  = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NUM_EV-1:0] evt_pulse,
   input logic [NUM_EV-1:0] stat,
   input logic [NUM_EV-1:0] ena,
   input logic              irq
);
   logic stat_wr_seen;
   logic ena_wr_seen;
   assign stat_wr_seen = reg_wr && (reg_addr == STAT_OFS);
   assign ena_wr_seen  = reg_wr && (reg_addr == ENA_OFS);

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_pulse) |=> ((stat & $past(evt_pulse)) == $past(evt_pulse))); // R2

   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr_seen |=> ((stat & $past(stat)) == $past(stat))); // R2

   AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_seen && evt_pulse == '0) |=>
         (stat == ($past(stat) & $past(reg_wdata[NUM_EV-1:0])))); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr_seen && (|evt_pulse)) |=>
         ((stat & $past(evt_pulse)) == $past(evt_pulse))); // R4

   AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ena_wr_seen |=> $stable(ena)); // R8

   AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:NUM_EV] == '0); // R7

   generate
      if (IRQ_REG) begin : g_irq_reg
         AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            ((stat & ena) != '0) |=> irq); // R6
      end else begin : g_irq_comb
         AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            irq == ((stat & ena) != '0)); // R6
      end
   endgenerate
endmodule

bind i2cm_stat_irq i2cm_stat_irq_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .NUM_EV  (NUM_EV),
   .STAT_OFS(STAT_OFS),
   .ENA_OFS (ENA_OFS),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .evt_pulse(evt_pulse),
   .stat     (stat_q),
   .ena      (ena_q),
   .irq      (irq)
);

// File: tb/sim_i2cm_stat_irq.sv
module sim_i2cm_stat_irq;
   localparam logic [7:0] A_STAT = 8'h0C;
   localparam logic [7:0] A_ENA  = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [6:0]  evt_pulse = '0;
   logic        irq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   i2cm_stat_irq u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse),
      .irq      (irq)
   );

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk);
      evt_pulse = m;
      @(negedge clk);
      evt_pulse = '0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      checks++;
      if (reg_rdata !== exp) begin
         failures++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, reg_rdata, exp);
      end
   endtask

   task automatic chk_irq(input logic exp, input string req);
      #1;
      checks++;
      if (irq !== exp) begin
         failures++;
         $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk_rd(A_STAT, 32'h0, "R1");
      chk_rd(A_ENA, 32'h0, "R1");
      chk_irq(1'b0, "R1");

      // R2 each event sets its own bit and stays set
      for (int i = 0; i < 7; i++) begin
         pulse(7'(1 << i));
         @(negedge clk);
         chk_rd(A_STAT, 32'(1 << i), "R2");
         wr(A_STAT, 32'h0);
         chk_rd(A_STAT, 32'h0, "R3");
      end

      // R3 sweep of every clear pattern from a full word
      for (int p = 0; p < 128; p++) begin
         pulse(7'h7F);
         wr(A_STAT, 32'(p));
         chk_rd(A_STAT, 32'(p), "R3");
      end

      // R9 partial acknowledge keeps the rest pending
      pulse(7'h7F);
      wr(A_STAT, 32'hFFFF_FFF6);
      chk_rd(A_STAT, 32'h76, "R9");
      pulse(7'h7F);
      wr(A_STAT, 32'hFFFF_FFFC);
      chk_rd(A_STAT, 32'h7C, "R9");
      wr(A_STAT, 32'h0);

      // R4 set beats clear in the same cycle
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0; evt_pulse = 7'h08;
      @(negedge clk);
      reg_wr = 1'b0; evt_pulse = '0;
      chk_rd(A_STAT, 32'h08, "R4");
      wr(A_STAT, 32'h0);

      // R5 / R7 enable readback, upper bits dropped
      wr(A_ENA, 32'hFFFF_FF2A);
      chk_rd(A_ENA, 32'h2A, "R5");
      chk_rd(A_ENA, 32'h2A, "R7");
      pulse(7'h7F);
      wr(A_STAT, 32'hFFFF_FFFF);
      chk_rd(A_STAT, 32'h7F, "R7");
      wr(A_STAT, 32'h0);

      // R6 irq over every enable value and several status patterns
      for (int e = 0; e < 128; e++) begin
         wr(A_ENA, 32'(e));
         chk_irq(1'b0, "R6");
         for (int s = 0; s < 7; s++) begin
            pulse(7'(1 << s));
            chk_irq(((e >> s) & 1) != 0, "R6");
            wr(A_STAT, 32'h0);
         end
      end
      // R6 level held until all enabled bits cleared
      wr(A_ENA, 32'h41);
      pulse(7'h41);
      repeat (4) @(negedge clk);
      chk_irq(1'b1, "R6");
      wr(A_STAT, 32'hFFFF_FFFE);
      chk_irq(1'b1, "R6");
      wr(A_STAT, 32'h0);
      chk_irq(1'b0, "R6");

      // R8 other offsets read zero and are write-inert
      wr(A_ENA, 32'h15);
      pulse(7'h33);
      wr(8'h10, 32'h0);
      wr(8'h08, 32'h0);
      wr(8'h00, 32'hFFFF_FFFF);
      chk_rd(A_STAT, 32'h33, "R8");
      chk_rd(A_ENA, 32'h15, "R8");
      chk_rd(8'h10, 32'h0, "R8");
      chk_rd(8'h04, 32'h0, "R8");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule